// File: doc/BRIEF.md
# Bus Ownership Arbiter with Request, Grant and Acknowledge Handshake

This block decides when a bus-master processor gives up its external bus. A single external master asks for the bus on an active-low request line. The arbiter answers on an active-low grant line. The external master then takes the bus and shows it on an active-low acknowledge line. The processor always has the lowest priority, so a request that is recognised is granted as soon as nothing holds it back. Both external lines may change at any time relative to the clock, so each passes through a flop synchronizer before any decision uses it.

Two conditions hold the grant back. The first is a locked read-modify-write sequence, which holds the grant for as long as the lock input is high. The second is a cycle that the processor's own bus sequencer is about to launch: the sequencer reports pending work, and no cycle is on the bus. The grant then waits until that cycle has started. A cycle that is already on the bus does not delay the grant, because a grant only means that the bus becomes free once that cycle ends. The `cpu_owns` output tells the internal sequencer whether it may start new cycles. All pins are plain control and status lines; no data stream crosses the block, so there is no valid/ready interface and no back-pressure.

Top module: `bus_arb_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after reset, `bus_grant_n` is 1 and `cpu_owns` is 1.
- R2: `bus_req_n` passes through SYNC_STAGES flops (default 2). Take a rising edge that samples the request low while no hold is active. After the edge SYNC_STAGES later (the third edge with the default), `bus_grant_n` reads 0.
- R3: `bus_grant_n` falls only when the synchronized request is asserted. `cpu_owns` is 0 from the same edge at which the grant asserts.
- R4: Once the synchronized acknowledge is seen while the grant is low, the next edge sets `bus_grant_n` to 1 and keeps `cpu_owns` at 0. `cpu_owns` returns to 1 at the edge after the synchronized acknowledge negates. With the defaults, this is the third edge after acknowledge is sampled high.
- R5: While `cyc_pending` is 1, no cycle is on the bus and `cyc_start` is 0, no grant asserts. The grant may assert at the edge where `cyc_start` is 1. A cycle counts as on the bus from the edge after `cyc_start` until the edge after `cyc_end`. A pending request while a cycle is on the bus does not delay the grant.
- R6: While `rmw_lock` is 1, no grant asserts. With the request held, the grant asserts at the first edge after `rmw_lock` drops to 0.
- R7: If the synchronized request negates while the grant is low and no acknowledge is seen, the next edge sets `bus_grant_n` to 1 and `cpu_owns` to 1.
- R8: `cpu_owns` is 0 in every cycle in which the synchronized acknowledge has been asserted for two or more consecutive cycles.
- R9: If an acknowledge is seen while the processor owns the bus and no grant is out, the processor yields. `cpu_owns` goes to 0 at the next edge and `bus_grant_n` stays 1, until the acknowledge negates as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req_n | input | 1 | Asynchronous active-low bus request from the external master |
| bus_ack_n | input | 1 | Asynchronous active-low grant acknowledge from the external master |
| rmw_lock | input | 1 | High while a locked read-modify-write sequence runs |
| cyc_pending | input | 1 | Internal sequencer has a cycle queued |
| cyc_start | input | 1 | One-cycle pulse: a bus cycle begins |
| cyc_end | input | 1 | One-cycle pulse: the bus cycle on the bus ends |
| bus_grant_n | output | 1 | Active-low bus grant |
| cpu_owns | output | 1 | High when the processor may start new bus cycles |

## Verification
The bench builds the block with SYNC_STAGES at its default of 2. Its reference model keeps a two-entry history for each external line, so the latency of every request and acknowledge can be checked to the exact edge. That depth lets the bench reach a request that is withdrawn within a synchronizer window, and an acknowledge that arrives with no grant out. It also reaches a lock or a launch hold that is still active when the synchronized request lands. A long pseudo-random phase mixes all inputs, including back-to-back start and end pulses.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_CPU   = 2'd0,
    ST_OFFER = 2'd1,
    ST_EXT   = 2'd2
  } arb_state_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= RST_VAL;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/arb_hold.sv
module arb_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic rmw_lock,
  input  logic cyc_pending,
  input  logic cyc_start,
  input  logic cyc_end,
  output logic grant_ok,
  output logic on_bus
);
  logic on_bus_q;
  logic launching;

  // A cycle occupies the bus from the edge after start to the edge after end.
  // Start wins over end so back-to-back cycles keep the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         on_bus_q <= 1'b0;
    else if (cyc_start) on_bus_q <= 1'b1;
    else if (cyc_end)   on_bus_q <= 1'b0;
  end

  // Committed but not yet begun: queued work with an idle bus.
  assign launching = cyc_pending && !on_bus_q && !cyc_start;
  assign grant_ok  = !rmw_lock && !launching;
  assign on_bus    = on_bus_q;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic ack_s,
  input  logic grant_ok,
  output logic grant_n,
  output logic owns
);
  arb_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CPU:   if (ack_s) st_d = ST_EXT;
                else if (req_s && grant_ok) st_d = ST_OFFER;
      ST_OFFER: if (ack_s) st_d = ST_EXT;
                else if (!req_s) st_d = ST_CPU;
      ST_EXT:   if (!ack_s) st_d = ST_CPU;
      default:  st_d = ST_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_CPU;
    else        st_q <= st_d;
  end

  assign grant_n = (st_q != ST_OFFER);
  assign owns    = (st_q == ST_CPU);

  // R4: acknowledge seen under grant drops the grant and keeps the bus away
  p_ack_takes_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n && ack_s) |=> (grant_n && !owns));

  // R7: request withdrawn before acknowledge returns the bus
  p_withdraw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_n && !req_s && !ack_s) |=> (grant_n && owns));
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic bus_ack_n,
  input  logic rmw_lock,
  input  logic cyc_pending,
  input  logic cyc_start,
  input  logic cyc_end,
  output logic bus_grant_n,
  output logic cpu_owns
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_n, sync_n;
  logic req_s, ack_s, grant_ok, on_bus;

  assign raw_n = {bus_ack_n, bus_req_n};

  arb_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES), .RST_VAL({NLINES{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(sync_n)
  );

  assign req_s = !sync_n[0];
  assign ack_s = !sync_n[1];

  arb_hold u_hold (
    .clk(clk), .rst_n(rst_n), .rmw_lock(rmw_lock), .cyc_pending(cyc_pending),
    .cyc_start(cyc_start), .cyc_end(cyc_end), .grant_ok(grant_ok), .on_bus(on_bus)
  );

  arb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .ack_s(ack_s),
    .grant_ok(grant_ok), .grant_n(bus_grant_n), .owns(cpu_owns)
  );

  // R3: grant only answers a synchronized request
  p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> $past(req_s));

  // R6: no grant out of a locked sequence
  p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> !$past(rmw_lock));

  // R5: no grant while a committed cycle has not begun
  p_defer_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_grant_n) |-> !($past(cyc_pending) && !$past(on_bus) && !$past(cyc_start)));

  // R8: processor and external master never own the bus together
  p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_s && $past(ack_s)) |-> !cpu_owns);
endmodule

// File: tb/bus_arb_ctrl_bench.sv
module bus_arb_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_n = 1'b1, bus_ack_n = 1'b1;
  logic rmw_lock = 1'b0, cyc_pending = 1'b0, cyc_start = 1'b0, cyc_end = 1'b0;
  logic bus_grant_n, cpu_owns;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_arb_ctrl u_bus_arb_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .bus_ack_n(bus_ack_n),
    .rmw_lock(rmw_lock), .cyc_pending(cyc_pending), .cyc_start(cyc_start),
    .cyc_end(cyc_end), .bus_grant_n(bus_grant_n), .cpu_owns(cpu_owns)
  );

  // Behavioural reference: 0 cpu, 1 offered, 2 external
  int m_st = 0;
  bit rq[2] = '{0, 0};
  bit aq[2] = '{0, 0};
  bit m_bus = 0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_st = 0; rq = '{0, 0}; aq = '{0, 0}; m_bus = 0;
    end else begin
      bit ok;
      ok = !rmw_lock && !(cyc_pending && !m_bus && !cyc_start);
      case (m_st)
        0: if (aq[1]) m_st = 2; else if (rq[1] && ok) m_st = 1;
        1: if (aq[1]) m_st = 2; else if (!rq[1]) m_st = 0;
        default: if (!aq[1]) m_st = 0;
      endcase
      if (cyc_start) m_bus = 1; else if (cyc_end) m_bus = 0;
      rq[1] = rq[0]; rq[0] = !bus_req_n;
      aq[1] = aq[0]; aq[0] = !bus_ack_n;
    end
  end

  task automatic chk(string tag, logic got, logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 grant vs model", bus_grant_n, logic'(m_st != 1));
      chk("R8 owner vs model", cpu_owns, logic'(m_st == 0));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    wait_n(3);
    chk("R1 grant in reset", bus_grant_n, 1'b1);
    chk("R1 owner in reset", cpu_owns, 1'b1);
    rst_n = 1'b1;
    wait_n(1);
    chk("R1 grant after reset", bus_grant_n, 1'b1);
    chk("R1 owner after reset", cpu_owns, 1'b1);

    // Basic handshake
    bus_req_n = 1'b0;
    wait_n(2);
    chk("R2 grant not before sync", bus_grant_n, 1'b1);
    wait_n(1);
    chk("R2 grant after sync", bus_grant_n, 1'b0);
    chk("R3 owner drops with grant", cpu_owns, 1'b0);
    bus_ack_n = 1'b0;
    wait_n(2);
    chk("R4 grant held before ack sync", bus_grant_n, 1'b0);
    wait_n(1);
    chk("R4 grant dropped on ack", bus_grant_n, 1'b1);
    chk("R4 owner stays low", cpu_owns, 1'b0);
    bus_req_n = 1'b1;
    wait_n(4);
    chk("R4 owner low while ack", cpu_owns, 1'b0);
    bus_ack_n = 1'b1;
    wait_n(2);
    chk("R8 owner low until ack sync", cpu_owns, 1'b0);
    wait_n(1);
    chk("R4 owner back", cpu_owns, 1'b1);

    // Locked sequence
    rmw_lock = 1'b1;
    bus_req_n = 1'b0;
    wait_n(6);
    chk("R6 no grant under lock", bus_grant_n, 1'b1);
    rmw_lock = 1'b0;
    wait_n(1);
    chk("R6 grant after unlock", bus_grant_n, 1'b0);
    // Withdraw request before acknowledge
    bus_req_n = 1'b1;
    wait_n(2);
    chk("R7 grant held in sync window", bus_grant_n, 1'b0);
    wait_n(1);
    chk("R7 grant withdrawn", bus_grant_n, 1'b1);
    chk("R7 owner restored", cpu_owns, 1'b1);

    // Committed launch defers grant
    cyc_pending = 1'b1;
    bus_req_n = 1'b0;
    wait_n(6);
    chk("R5 deferred while launching", bus_grant_n, 1'b1);
    cyc_start = 1'b1;
    wait_n(1);
    chk("R5 grant once cycle begins", bus_grant_n, 1'b0);
    cyc_start = 1'b0;
    cyc_pending = 1'b0;
    bus_req_n = 1'b1;
    wait_n(2);
    cyc_end = 1'b1;
    wait_n(1);
    cyc_end = 1'b0;
    wait_n(2);
    chk("R7 owner after withdraw", cpu_owns, 1'b1);

    // Pending while a cycle is on the bus: no deferral
    cyc_start = 1'b1;
    wait_n(1);
    cyc_start = 1'b0;
    cyc_pending = 1'b1;
    bus_req_n = 1'b0;
    wait_n(3);
    chk("R5 no deferral with cycle on bus", bus_grant_n, 1'b0);
    bus_req_n = 1'b1;
    cyc_end = 1'b1;
    wait_n(1);
    cyc_end = 1'b0;
    cyc_pending = 1'b0;
    wait_n(4);

    // Acknowledge without grant
    bus_ack_n = 1'b0;
    wait_n(2);
    chk("R9 owner before ack sync", cpu_owns, 1'b1);
    wait_n(1);
    chk("R9 owner yields", cpu_owns, 1'b0);
    chk("R9 no grant", bus_grant_n, 1'b1);
    bus_ack_n = 1'b1;
    wait_n(3);
    chk("R9 owner back", cpu_owns, 1'b1);

    // Pseudo-random mix, compared every cycle
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (lf[2:0] == 3'd0) bus_req_n = ~bus_req_n;
        if (lf[6:4] == 3'd1) bus_ack_n = ~bus_ack_n;
        rmw_lock    = (lf[9:7] == 3'd0);
        cyc_pending = lf[10];
        cyc_start   = lf[12:11] == 2'd3;
        cyc_end     = lf[14:13] == 2'd2;
        wait_n(1);
      end
    end
    done = 1;
    summary();
  end
endmodule